// File: doc/BRIEF.md
# Immediate-Add Bit-Window Branch Evaluator

This block carries out the arithmetic part of one conditional-branch instruction in a 64-bit register-machine core. It takes the current value of the destination register, a 32-bit immediate and a 4-bit condition code. From the condition code it derives a bit position. It turns the immediate into a 64-bit addend in which the bit at that position is forced high and the bit just below it is forced low. It adds this addend to the register. It then tests a window of bits in the sum, starting at that position, and reports the branch as taken when every bit in the window is zero.

The sum is always returned for write-back, whether or not the branch is taken. The base offset of the bit position and the width of the tested window are elaboration parameters. A request is presented with `in_valid`, and the sum and decision are registered so that they appear on the following clock with `out_valid`. The block does not compute the jump target. That remains the job of the sequencer around it.

Top module: `imm_branch_eval`

## Requirements
- R1: The bit position b equals the unsigned condition code plus the parameter JUMP_OFFSET (default 8, so condition 15 gives b = 23 and condition 4 gives b = 12).
- R2: The addend is the immediate sign-extended from bit 31 to 64 bits, with bit b then set to 1.
- R3: When b is greater than 0, bit b-1 of the addend is cleared. When b is 0, no bit of the sign-extended immediate other than bit 0 is altered.
- R4: `out_sum` equals `in_reg` plus the addend, modulo 2^64, and it is produced whether or not the branch is taken.
- R5: `out_taken` is 1 exactly when bits b through b+JUMP_BITS-1 of the sum are all zero (bit 0 is the least significant bit). With the defaults, condition 15 tests mask 0x7F800000 and condition 4 tests mask 0x000FF000.
- R6: A request sampled with `in_valid` high at a rising edge produces `out_valid` high, together with its `out_sum` and `out_taken`, on that same edge's output, one clock later. `out_valid` is low after any edge where `in_valid` was low.
- R7: A synchronous active-high `rst` clears `out_valid` at the next rising edge, even if `in_valid` is high in that cycle.
- R8: While `in_valid` is low, `out_sum` and `out_taken` keep their last values, whatever `in_reg`, `in_imm` and `in_cond` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_reg | input | 64 | Current destination register value |
| in_imm | input | 32 | Signed immediate |
| in_cond | input | 4 | Condition code that selects the bit position |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_sum | output | 64 | Updated register value for write-back |
| out_taken | output | 1 | Branch decision: tested window is all zero |

## Verification
The bench aims sums at the edges of the tested window, placing a single one at b-1, b, b+JUMP_BITS-1 and b+JUMP_BITS. A design with the window shifted by one position, or one bit too wide or too narrow, would then take a branch it should not take, or miss one it should take. A second instance built with a zero offset exercises b = 0. There, a design that cleared a bit below position 0 (wrapping to bit 63) or that cleared bit 0 itself would return a wrong sum. Negative immediates show up any failure to sign-extend. The bench also varies the inputs while `in_valid` is low and raises `rst` together with a request, which exposes a register that captures data without a valid request or a reset that loses to the valid input.

// File: rtl/ibe_pkg.sv
package ibe_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned IMM_W  = 32;
  localparam int unsigned COND_W = 4;
  localparam int unsigned POS_W  = $clog2(DATA_W);

  // Sign-extend the instruction immediate to the register width.
  function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] imm);
    return {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  // Window of jb ones whose lowest bit sits at position b.
  function automatic logic [DATA_W-1:0] window_mask(input logic [POS_W-1:0] b,
                                                   input int unsigned jb);
    logic [DATA_W-1:0] ones;
    ones = (DATA_W'(1) << jb) - DATA_W'(1);
    return ones << b;
  endfunction

  // Addend: force bit b high and bit b-1 low.
  function automatic logic [DATA_W-1:0] shape_addend(input logic [DATA_W-1:0] base,
                                                    input logic [POS_W-1:0] b);
    logic [DATA_W-1:0] set_bit;
    logic [DATA_W-1:0] clr_bit;
    set_bit = DATA_W'(1) << b;
    // For b == 0 the right shift yields zero, so nothing is cleared.
    clr_bit = set_bit >> 1;
    return (base & ~clr_bit) | set_bit;
  endfunction
endpackage

// File: rtl/ibe_const_gen.sv
module ibe_const_gen
  import ibe_pkg::*;
#(
  parameter int unsigned JUMP_OFFSET = 8
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [COND_W-1:0] cond,
  output logic [POS_W-1:0]  bpos,
  output logic [DATA_W-1:0] addend
);
  logic [DATA_W-1:0] base_w;

  assign bpos   = POS_W'(cond) + POS_W'(JUMP_OFFSET);
  assign base_w = sext_imm(imm);
  assign addend = shape_addend(base_w, bpos);
endmodule

// File: rtl/ibe_window_test.sv
module ibe_window_test
  import ibe_pkg::*;
#(
  parameter int unsigned JUMP_OFFSET = 8,
  parameter int unsigned JUMP_BITS   = 8
) (
  input  logic [COND_W-1:0] cond,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] mask,
  output logic              all_zero
);
  localparam int unsigned N_COND = 2 ** COND_W;

  logic [DATA_W-1:0] mask_tab [N_COND];

  // One constant mask per condition code; cond only steers a mux.
  for (genvar c = 0; c < N_COND; c++) begin : g_mask
    assign mask_tab[c] = window_mask(POS_W'(c + JUMP_OFFSET), JUMP_BITS);
  end

  assign mask     = mask_tab[cond];
  assign all_zero = ~|(value & mask);
endmodule

// File: rtl/imm_branch_eval.sv
module imm_branch_eval
  import ibe_pkg::*;
#(
  parameter int unsigned JUMP_OFFSET = 8,
  parameter int unsigned JUMP_BITS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_reg,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [COND_W-1:0] in_cond,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sum,
  output logic              out_taken
);
  // Named internal events, visible to the bound checker.
  logic [POS_W-1:0]  bpos_w;
  logic [DATA_W-1:0] addend_w;
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] mask_w;
  logic              hit_w;

  ibe_const_gen #(
    .JUMP_OFFSET(JUMP_OFFSET)
  ) const_i (
    .imm   (in_imm),
    .cond  (in_cond),
    .bpos  (bpos_w),
    .addend(addend_w)
  );

  assign sum_w = in_reg + addend_w;

  ibe_window_test #(
    .JUMP_OFFSET(JUMP_OFFSET),
    .JUMP_BITS  (JUMP_BITS)
  ) window_i (
    .cond    (in_cond),
    .value   (sum_w),
    .mask    (mask_w),
    .all_zero(hit_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
    if (!rst && in_valid) begin
      out_sum   <= sum_w;
      out_taken <= hit_w;
    end
  end
endmodule

// File: rtl/imm_branch_eval_chk.sv
module imm_branch_eval_chk
  import ibe_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_reg,
  input logic [IMM_W-1:0]  in_imm,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_sum,
  input logic              out_taken,
  input logic [POS_W-1:0]  bpos_w,
  input logic [DATA_W-1:0] addend_w,
  input logic [DATA_W-1:0] mask_w
);
  assert_forced_bit_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (addend_w[bpos_w] && (addend_w[DATA_W-1] == in_imm[IMM_W-1])));

  assert_cleared_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bpos_w != '0) |-> !addend_w[bpos_w - POS_W'(1)]);

  assert_sum_writeback_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum == $past(in_reg) + $past(addend_w)));

  assert_window_decision_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_taken == ((out_sum & $past(mask_w)) == '0)));

  assert_one_cycle_latency_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_sum) && $stable(out_taken)));
endmodule

bind imm_branch_eval imm_branch_eval_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_reg   (in_reg),
  .in_imm   (in_imm),
  .out_valid(out_valid),
  .out_sum  (out_sum),
  .out_taken(out_taken),
  .bpos_w   (bpos_w),
  .addend_w (addend_w),
  .mask_w   (mask_w)
);

// File: tb/imm_branch_eval_tb_top.sv
module imm_branch_eval_tb_top;
  localparam int OFS_A = 8;
  localparam int OFS_B = 0;
  localparam int JB    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [63:0] in_reg   = '0;
  logic [31:0] in_imm   = '0;
  logic [3:0]  in_cond  = '0;
  logic        ov_a, tk_a, ov_b, tk_b;
  logic [63:0] sum_a, sum_b;

  imm_branch_eval #(.JUMP_OFFSET(OFS_A), .JUMP_BITS(JB)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_reg(in_reg), .in_imm(in_imm),
    .in_cond(in_cond), .out_valid(ov_a), .out_sum(sum_a), .out_taken(tk_a));

  imm_branch_eval #(.JUMP_OFFSET(OFS_B), .JUMP_BITS(JB)) dut0_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_reg(in_reg), .in_imm(in_imm),
    .in_cond(in_cond), .out_valid(ov_b), .out_sum(sum_b), .out_taken(tk_b));

  typedef struct packed {
    logic [63:0] sum;
    logic        taken;
  } exp_t;

  exp_t        q_a[$];
  exp_t        q_b[$];
  int          checks = 0;
  int          fails  = 0;
  logic [63:0] last_a = '0;
  logic [63:0] last_b = '0;
  bit          done   = 0;

  // Reference model written from the requirements.
  function automatic logic [63:0] model_addend(logic [31:0] imm, logic [3:0] cond, int ofs);
    int          b;
    logic [63:0] v;
    b = int'(cond) + ofs;
    v = {{32{imm[31]}}, imm};
    v[b] = 1'b1;
    if (b > 0) v[b-1] = 1'b0;
    return v;
  endfunction

  function automatic logic model_taken(logic [63:0] s, logic [3:0] cond, int ofs);
    int b;
    b = int'(cond) + ofs;
    for (int i = 0; i < JB; i++) if (s[b+i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] r, logic [31:0] imm, logic [3:0] cond);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_reg   = r;
    in_imm   = imm;
    in_cond  = cond;
    e.sum   = r + model_addend(imm, cond, OFS_A);
    e.taken = model_taken(e.sum, cond, OFS_A);
    q_a.push_back(e);
    e.sum   = r + model_addend(imm, cond, OFS_B);
    e.taken = model_taken(e.sum, cond, OFS_B);
    q_b.push_back(e);
  endtask

  // Choose the register so that the offset-8 instance produces a given sum.
  task automatic drive_sum(logic [63:0] target, logic [31:0] imm, logic [3:0] cond);
    drive(target - model_addend(imm, cond, OFS_A), imm, cond);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard as results arrive.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && !done) begin
      if (ov_a) begin
        if (q_a.size() == 0) check(1'b0, "R6 unexpected valid (offset 8)", 64'd1, 64'd0);
        else begin
          e = q_a.pop_front();
          check(sum_a == e.sum, "R1 R2 R3 R4 sum (offset 8)", sum_a, e.sum);
          check(tk_a == e.taken, "R5 taken (offset 8)", 64'(tk_a), 64'(e.taken));
          last_a = sum_a;
        end
      end
      if (ov_b) begin
        if (q_b.size() == 0) check(1'b0, "R6 unexpected valid (offset 0)", 64'd1, 64'd0);
        else begin
          e = q_b.pop_front();
          check(sum_b == e.sum, "R1 R2 R3 R4 sum (offset 0)", sum_b, e.sum);
          check(tk_b == e.taken, "R5 taken (offset 0)", 64'(tk_b), 64'(e.taken));
          last_b = sum_b;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    check(!ov_a && !ov_b, "R7 reset state", 64'({ov_a, ov_b}), 64'd0);
    rst = 1'b0;

    // R2: zero immediate, condition 15 -> addend 1<<23, window bit 23 set, not taken.
    drive(64'd0, 32'h0, 4'd15);
    // R5: sum of zero is taken.
    drive_sum(64'd0, 32'h1234_5678, 4'd4);
    // R2: negative immediate checks sign extension.
    drive(64'h0123_4567_89AB_CDEF, 32'h8000_0001, 4'd2);
    drive(64'hFFFF_0000_0000_0000, 32'hFFFF_FFFF, 4'd9);

    // R5: ones just outside and just inside the window edges.
    for (int c = 0; c < 16; c += 5) begin
      b = c + OFS_A;
      drive_sum(64'd1 << (b - 1),      32'h7654_3210, 4'(c));
      drive_sum(64'd1 << (b + JB),     32'h0BAD_F00D, 4'(c));
      drive_sum(64'd1 << b,            32'hDEAD_BEEF, 4'(c));
      drive_sum(64'd1 << (b + JB - 1), 32'h0000_0042, 4'(c));
    end

    // R3: b = 0 and b = 1 on the zero-offset instance.
    drive(64'd0, 32'h0, 4'd0);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 4'd0);
    drive(64'd0, 32'hFFFF_FFFF, 4'd0);
    drive(64'd0, 32'hFFFF_FFFF, 4'd1);

    // R1: every condition code with random operands, half aimed at taken.
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 6; k++) begin
        if (k[0]) drive_sum({$urandom, $urandom} & ~(64'hFF << (c + OFS_A)), $urandom, 4'(c));
        else      drive({$urandom, $urandom}, $urandom, 4'(c));
      end
    end

    // R8: inputs move while idle, outputs must hold.
    go_idle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_reg  = {$urandom, $urandom};
      in_imm  = $urandom;
      in_cond = 4'($urandom);
    end
    check(!ov_a && !ov_b, "R6 valid low when idle", 64'({ov_a, ov_b}), 64'd0);
    check(sum_a == last_a, "R8 hold sum (offset 8)", sum_a, last_a);
    check(sum_b == last_b, "R8 hold sum (offset 0)", sum_b, last_b);

    // R7: reset wins over a request in the same cycle.
    @(negedge clk);
    in_valid = 1'b1;
    rst      = 1'b1;
    @(negedge clk);
    check(!ov_a && !ov_b, "R7 reset beats valid", 64'({ov_a, ov_b}), 64'd0);
    in_valid = 1'b0;
    rst      = 1'b0;

    drive_sum(64'd0, 32'h0000_1000, 4'd7);
    go_idle();
    repeat (3) @(negedge clk);
    check(q_a.size() == 0 && q_b.size() == 0, "R6 every request answered",
          64'(q_a.size() + q_b.size()), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule